// File: doc/BRIEF.md
# Banked data memory address generator

This block resolves the 12-bit address of every access to a 4 KB data register file that is split into sixteen banks of 256 bytes. The memory array itself is outside the block. Only the address comes out, and it is combinational from the current inputs and the stored state.

A direct access takes an 8-bit offset from the instruction. A mode bit then picks one of two ways to complete it. In banked mode the upper four bits come from a bank register. In access mode a fixed map applies. The lower half of the offset range lands at the bottom of bank 0. The upper half lands at the top of bank 15. The bank register plays no part in access mode.

An indirect access takes its whole address from one of three 12-bit pointers. Any pointer can be loaded with a full 12-bit value in one cycle. A pointer can also step by one after the access that uses it.

Top module: `data_addr_gen`

## Requirements
- R1: After reset the bank register is 0 and every pointer is 0x000.
- R2: In a direct access with `banked_i`=1, `addr_o` equals {bank register, `ofs_i`}.
- R3: In a direct access with `banked_i`=0 and `ofs_i` below 0x80, `addr_o` equals 0x000 + `ofs_i`, whatever the bank register holds.
- R4: In a direct access with `banked_i`=0 and `ofs_i` of 0x80 or above, `addr_o` equals 0xF00 + `ofs_i` (0xF80 to 0xFFF), whatever the bank register holds.
- R5: When `bank_we_i` is 1 at a clock edge, the bank register takes `bank_d_i`. When `bank_we_i` is 0, the bank register keeps its value whatever `bank_d_i` does.
- R6: When `ind_i`=1 and `ptr_sel_i` is 0, 1 or 2, `addr_o` equals the selected pointer. `ofs_i`, `banked_i` and the bank register have no effect on it.
- R7: When `ptr_ld_i`=1 at a clock edge, the pointer numbered `ptr_ld_sel_i` takes all 12 bits of `ptr_ld_d_i`.
- R8: When `ind_i`=1 and `post_inc_i`=1, `addr_o` shows the current pointer value in that cycle. After the edge the pointer holds that value plus 1, modulo 4096, so 0xFFF is followed by 0x000.
- R9: If one pointer is loaded and post-incremented at the same edge, the load wins. If a load and an increment target different pointers at the same edge, both take effect.
- R10: `post_inc_i` has no effect on any pointer while `ind_i` is 0.
- R11: When `ind_i`=1 and `ptr_sel_i`=3, `addr_o` is 0x000 and no pointer changes, even if `post_inc_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bank_we_i | input | 1 | Bank register load enable |
| bank_d_i | input | 4 | New bank number |
| ofs_i | input | 8 | Offset field from the instruction |
| banked_i | input | 1 | 1 = banked mode, 0 = access mode (direct accesses only) |
| ind_i | input | 1 | 1 = indirect access through a pointer |
| ptr_sel_i | input | 2 | Pointer used by an indirect access |
| post_inc_i | input | 1 | Step the selected pointer after the access |
| ptr_ld_i | input | 1 | Pointer load enable |
| ptr_ld_sel_i | input | 2 | Pointer to load |
| ptr_ld_d_i | input | 12 | 12-bit load value |
| addr_o | output | 12 | Resolved data memory address |

## Verification
The bench builds the block with its default parameters: an 8-bit offset, a 4-bit bank and three pointers. With these values the whole direct address space is small. All 256 offsets are swept in both modes for each of the sixteen bank values, so both edges of the access-bank split are covered against every bank. Pointer loads cover the 12-bit range in steps. An increment run crosses 0xFFF so that the wrap is seen. The same-edge collisions of load and increment are driven on purpose.

// File: rtl/dag_pkg.sv
package dag_pkg;
  typedef enum logic {
    MAP_ACCESS = 1'b0,
    MAP_BANKED = 1'b1
  } map_mode_e;
endpackage

// File: rtl/dag_bank_reg.sv
module dag_bank_reg #(
  parameter int unsigned BANK_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [BANK_W-1:0] d_i,
  output logic [BANK_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/dag_direct_map.sv
module dag_direct_map
  import dag_pkg::*;
#(
  parameter int unsigned OFS_W  = 8,
  parameter int unsigned BANK_W = 4
) (
  input  logic [BANK_W-1:0]       bank_i,
  input  logic [OFS_W-1:0]        ofs_i,
  input  map_mode_e               mode_i,
  output logic [BANK_W+OFS_W-1:0] addr_o
);
  logic [BANK_W-1:0] hi;

  // access mode: the offset MSB picks the bottom or the top bank
  always_comb begin
    if (mode_i == MAP_BANKED) hi = bank_i;
    else                      hi = {BANK_W{ofs_i[OFS_W-1]}};
    addr_o = {hi, ofs_i};
  end
endmodule

// File: rtl/dag_ptr_file.sv
module dag_ptr_file #(
  parameter int unsigned NUM_PTR = 3,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned SEL_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEL_W-1:0]  rd_sel_i,
  input  logic              inc_i,
  input  logic              ld_i,
  input  logic [SEL_W-1:0]  ld_sel_i,
  input  logic [ADDR_W-1:0] ld_d_i,
  output logic [ADDR_W-1:0] rd_o
);
  logic [ADDR_W-1:0] ptr_q [NUM_PTR];

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
    logic ld_hit, inc_hit;
    assign ld_hit  = ld_i  && (ld_sel_i == SEL_W'(g));
    assign inc_hit = inc_i && (rd_sel_i == SEL_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      ptr_q[g] <= '0;
      else if (ld_hit)  ptr_q[g] <= ld_d_i;
      else if (inc_hit) ptr_q[g] <= ptr_q[g] + ADDR_W'(1);
    end
  end

  // unmapped index reads as zero
  always_comb begin
    rd_o = '0;
    for (int i = 0; i < NUM_PTR; i++)
      if (rd_sel_i == SEL_W'(i)) rd_o = ptr_q[i];
  end
endmodule

// File: rtl/data_addr_gen.sv
module data_addr_gen
  import dag_pkg::*;
#(
  parameter int unsigned OFS_W   = 8,
  parameter int unsigned BANK_W  = 4,
  parameter int unsigned NUM_PTR = 3,
  localparam int unsigned ADDR_W = OFS_W + BANK_W,
  localparam int unsigned SEL_W  = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bank_we_i,
  input  logic [BANK_W-1:0] bank_d_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic              banked_i,
  input  logic              ind_i,
  input  logic [SEL_W-1:0]  ptr_sel_i,
  input  logic              post_inc_i,
  input  logic              ptr_ld_i,
  input  logic [SEL_W-1:0]  ptr_ld_sel_i,
  input  logic [ADDR_W-1:0] ptr_ld_d_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [BANK_W-1:0] bank_q;
  logic [ADDR_W-1:0] dir_addr, ind_addr;
  map_mode_e         mode;

  assign mode = banked_i ? MAP_BANKED : MAP_ACCESS;

  dag_bank_reg #(.BANK_W(BANK_W)) i_bank (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (bank_we_i),
    .d_i   (bank_d_i),
    .q_o   (bank_q)
  );

  dag_direct_map #(.OFS_W(OFS_W), .BANK_W(BANK_W)) i_map (
    .bank_i(bank_q),
    .ofs_i (ofs_i),
    .mode_i(mode),
    .addr_o(dir_addr)
  );

  dag_ptr_file #(.NUM_PTR(NUM_PTR), .ADDR_W(ADDR_W), .SEL_W(SEL_W)) i_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_sel_i(ptr_sel_i),
    .inc_i   (ind_i && post_inc_i),
    .ld_i    (ptr_ld_i),
    .ld_sel_i(ptr_ld_sel_i),
    .ld_d_i  (ptr_ld_d_i),
    .rd_o    (ind_addr)
  );

  assign addr_o = ind_i ? ind_addr : dir_addr;
endmodule

// File: rtl/data_addr_gen_chk.sv
module data_addr_gen_chk #(
  parameter int unsigned OFS_W   = 8,
  parameter int unsigned BANK_W  = 4,
  parameter int unsigned NUM_PTR = 3,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned SEL_W   = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bank_we_i,
  input logic [BANK_W-1:0] bank_d_i,
  input logic [OFS_W-1:0]  ofs_i,
  input logic              banked_i,
  input logic              ind_i,
  input logic [SEL_W-1:0]  ptr_sel_i,
  input logic              post_inc_i,
  input logic              ptr_ld_i,
  input logic [SEL_W-1:0]  ptr_ld_sel_i,
  input logic [ADDR_W-1:0] ptr_ld_d_i,
  input logic [ADDR_W-1:0] addr_o
);
  p_access_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ind_i && !banked_i && !ofs_i[OFS_W-1]) |-> (addr_o == {{BANK_W{1'b0}}, ofs_i}));

  p_access_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ind_i && !banked_i && ofs_i[OFS_W-1]) |-> (addr_o == {{BANK_W{1'b1}}, ofs_i}));

  p_bank_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_we_i |=> (ind_i || !banked_i || addr_o[ADDR_W-1:OFS_W] == $past(bank_d_i)));

  p_ptr_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_ld_i |=> (!ind_i || ptr_sel_i != $past(ptr_ld_sel_i) || addr_o == $past(ptr_ld_d_i)));

  p_post_inc_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ind_i && post_inc_i && 32'(ptr_sel_i) < NUM_PTR &&
     !(ptr_ld_i && ptr_ld_sel_i == ptr_sel_i))
    |=> (!ind_i || ptr_sel_i != $past(ptr_sel_i) ||
         addr_o == ADDR_W'($past(addr_o) + ADDR_W'(1))));

  p_bad_sel_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ind_i && 32'(ptr_sel_i) >= NUM_PTR) |-> (addr_o == '0));
endmodule

bind data_addr_gen data_addr_gen_chk #(
  .OFS_W(OFS_W), .BANK_W(BANK_W), .NUM_PTR(NUM_PTR), .ADDR_W(ADDR_W), .SEL_W(SEL_W)
) i_chk (.*);

// File: tb/test_data_addr_gen.sv
`timescale 1ns/1ps
module test_data_addr_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bank_we_i = 1'b0;
  logic [3:0]  bank_d_i = '0;
  logic [7:0]  ofs_i = '0;
  logic        banked_i = 1'b0;
  logic        ind_i = 1'b0;
  logic [1:0]  ptr_sel_i = '0;
  logic        post_inc_i = 1'b0;
  logic        ptr_ld_i = 1'b0;
  logic [1:0]  ptr_ld_sel_i = '0;
  logic [11:0] ptr_ld_d_i = '0;
  logic [11:0] addr_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [11:0] ptr_m [3];

  always #2 clk_i = ~clk_i;

  data_addr_gen i_data_addr_gen (.*);

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_all(input string req);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      ind_i = 1'b1; post_inc_i = 1'b0; ptr_sel_i = 2'(k);
      #1 chk(req, addr_o, ptr_m[k]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    @(negedge clk_i);
    banked_i = 1'b1; ofs_i = 8'h34;
    #1 chk("R1 bank", addr_o, 12'h034);
    for (int k = 0; k < 3; k++) ptr_m[k] = '0;
    read_all("R1 ptr");
    ind_i = 1'b0;

    // R2..R5 sweep over all banks and offsets
    for (int b = 0; b < 16; b++) begin
      @(negedge clk_i);
      bank_we_i = 1'b1; bank_d_i = 4'(b);
      @(negedge clk_i);
      bank_we_i = 1'b0; bank_d_i = ~4'(b);
      @(negedge clk_i);
      banked_i = 1'b1; ofs_i = 8'h00;
      #1 chk("R5 hold", addr_o, {4'(b), 8'h00});
      for (int o = 0; o < 256; o++) begin
        @(negedge clk_i);
        ofs_i = 8'(o); banked_i = 1'b1;
        #0.5 chk("R2", addr_o, {4'(b), 8'(o)});
        banked_i = 1'b0;
        #0.5 if (o < 128) chk("R3", addr_o, {4'h0, 8'(o)});
             else         chk("R4", addr_o, {4'hF, 8'(o)});
      end
    end

    // R7 loads over the range, R6 reads independent of direct inputs
    for (int v = 0; v < 4096; v += 37) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk_i);
        ind_i = 1'b0; ptr_ld_i = 1'b1; ptr_ld_sel_i = 2'(k);
        ptr_ld_d_i = 12'(v + k * 1365);
        ptr_m[k] = 12'(v + k * 1365);
      end
      @(negedge clk_i);
      ptr_ld_i = 1'b0;
      for (int k = 0; k < 3; k++) begin
        @(negedge clk_i);
        ind_i = 1'b1; ptr_sel_i = 2'(k);
        ofs_i = 8'(v); banked_i = v[0];
        #1 chk("R7 R6", addr_o, ptr_m[k]);
      end
    end

    // R8 post-increment across the wrap
    @(negedge clk_i);
    ind_i = 1'b0; ptr_ld_i = 1'b1; ptr_ld_sel_i = 2'd1; ptr_ld_d_i = 12'hFF0;
    ptr_m[1] = 12'hFF0;
    @(negedge clk_i);
    ptr_ld_i = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i);
      ind_i = 1'b1; ptr_sel_i = 2'd1; post_inc_i = 1'b1;
      #1 chk("R8", addr_o, ptr_m[1]);
      ptr_m[1] = ptr_m[1] + 12'd1;
    end
    read_all("R8 after");

    // R9 load beats increment on the same pointer
    @(negedge clk_i);
    ind_i = 1'b1; ptr_sel_i = 2'd2; post_inc_i = 1'b1;
    ptr_ld_i = 1'b1; ptr_ld_sel_i = 2'd2; ptr_ld_d_i = 12'h123;
    #1 chk("R9 old", addr_o, ptr_m[2]);
    ptr_m[2] = 12'h123;
    @(negedge clk_i);
    ptr_ld_i = 1'b0; post_inc_i = 1'b0;
    #1 chk("R9 load", addr_o, 12'h123);
    // R9 load and increment on different pointers
    @(negedge clk_i);
    ind_i = 1'b1; ptr_sel_i = 2'd2; post_inc_i = 1'b1;
    ptr_ld_i = 1'b1; ptr_ld_sel_i = 2'd0; ptr_ld_d_i = 12'hABC;
    ptr_m[0] = 12'hABC; ptr_m[2] = 12'h124;
    @(negedge clk_i);
    ptr_ld_i = 1'b0; post_inc_i = 1'b0;
    read_all("R9 both");

    // R10 post_inc without indirect access
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i);
      ind_i = 1'b0; post_inc_i = 1'b1; ptr_sel_i = 2'(i % 3); banked_i = 1'b1;
    end
    @(negedge clk_i);
    post_inc_i = 1'b0;
    read_all("R10");

    // R11 unmapped pointer index
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      ind_i = 1'b1; ptr_sel_i = 2'd3; post_inc_i = 1'b1; ofs_i = 8'hC3;
      #1 chk("R11 addr", addr_o, 12'h000);
    end
    @(negedge clk_i);
    post_inc_i = 1'b0;
    read_all("R11 ptr");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule